// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two unsigned operands of `WIDTH` bits using one full adder that handles one bit position per clock. Both operands are captured in parallel into two shift registers: the augend register and the addend register. On each accepted shift, both registers move one place toward the least significant end. The bit leaving each register goes into the full adder together with a stored carry. The sum bit enters the augend register at its most significant end, so after `WIDTH` accepted shifts that register holds the result.

A load starts an addition. Each accepted shift processes one bit position, and a small counter tracks how many positions are done. After the last position it gives a one-cycle `done` pulse and accepts no further shifts until the next load. The carry flip-flop after the final shift is the carry out of the whole sum. The `B_RECIRC` parameter selects what enters the addend register: 0 feeds in zeros, and 1 feeds its own outgoing bit back so that the addend is kept.

Top module: `serial_adder`

## Requirements
- R1: After reset, `sum_q`, `addend_q`, `carry_out` and `done` are 0, and `shift_en` has no effect until the first load.
- R2: A cycle with `load` high makes `sum_q` equal `op_a` and `addend_q` equal `op_b` on the next cycle, clears `carry_out`, and restarts the bit count.
- R3: `load` wins over `shift_en` and `carry_clr` in the same cycle: the registers take the new operands and no shift occurs.
- R4: While `shift_en` is low and neither `load` nor `carry_clr` is high, `sum_q`, `addend_q` and `carry_out` keep their values.
- R5: After exactly `WIDTH` accepted shifts, `sum_q` equals (op_a + op_b) mod 2^WIDTH, and `carry_out` equals bit `WIDTH` of op_a + op_b.
- R6: `done` is high for exactly one cycle. That cycle directly follows the clock edge of the `WIDTH`-th accepted shift, and `done` never rises earlier.
- R7: Once `done` has pulsed, `shift_en` is ignored (`sum_q`, `addend_q` and `carry_out` are unchanged) until the next load.
- R8: `carry_clr` high without `load` forces `carry_out` to 0 on the next cycle. No shift is accepted in that cycle, so the registers hold and the bit count is unchanged.
- R9: With `B_RECIRC`=0, `addend_q` is 0 after `done`. With `B_RECIRC`=1, `addend_q` equals the loaded `op_b` after `done`.
- R10: Cycles with `shift_en` low, placed anywhere between accepted shifts, do not change the final `sum_q` or `carry_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| carry_clr | input | 1 | Clears the carry flip-flop; no shift occurs in that cycle |
| load | input | 1 | Captures both operands and starts an addition |
| op_a | input | WIDTH | Augend, parallel input |
| op_b | input | WIDTH | Addend, parallel input |
| shift_en | input | 1 | Requests one bit-serial step |
| sum_q | output | WIDTH | Augend register contents; holds the sum after completion |
| addend_q | output | WIDTH | Addend register contents |
| carry_out | output | 1 | Carry flip-flop; the final carry after completion |
| done | output | 1 | One-cycle pulse when the last bit position has been added |

## Verification
The assertions check these on every cycle: operand capture on load, the holding of both registers when no shift is accepted, carry clearing, that `done` lasts one cycle, and that `done` only occurs once the sequencer has stopped. Only the bench scenarios can show that the arithmetic result and the final carry are correct after a complete pass. The same applies to the effect of shift pauses and of a mid-operation carry clear on the sum, and to the addend contents in both `B_RECIRC` variants.

// File: rtl/sadd_pkg.sv
package sadd_pkg;
  // full-adder arithmetic, kept here so the datapath and its checks share one definition
  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/sadd_shreg.sv
module sadd_shreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q,
  output logic             ser_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= par_in;
    else if (shift) q <= {ser_in, q[WIDTH-1:1]};
  end

  assign ser_out = q[0];

  // R2: parallel capture
  p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(par_in));
  // R4: no load and no shift means the register holds
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(q));
endmodule

// File: rtl/sadd_carry.sv
module sadd_carry (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic upd,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (upd) q <= d;
  end

  // R8: clearing forces zero on the next cycle
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !q);
  // R4: without clear or update the carry holds
  p_carry_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !upd) |=> $stable(q));
endmodule

// File: rtl/sadd_seq.sv
module sadd_seq #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic hold,
  input  logic shift_req,
  output logic shift_go,
  output logic done
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [CW-1:0] bit_cnt;
  logic          busy;
  logic          last_step;

  assign shift_go  = shift_req && busy && !load && !hold;
  assign last_step = shift_go && (bit_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= last_step;
      if (load) begin
        bit_cnt <= '0;
        busy    <= 1'b1;
      end else if (shift_go) begin
        bit_cnt <= bit_cnt + 1'b1;
        if (last_step) busy <= 1'b0;
      end
    end
  end

  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: once done, the sequencer no longer accepts shifts
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R3: no shift is taken in a load cycle
  p_load_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !shift_go);
endmodule

// File: rtl/serial_adder.sv
module serial_adder #(
  parameter int WIDTH    = 8,
  parameter bit B_RECIRC = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             carry_clr,
  input  logic             load,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             shift_en,
  output logic [WIDTH-1:0] sum_q,
  output logic [WIDTH-1:0] addend_q,
  output logic             carry_out,
  output logic             done
);
  import sadd_pkg::*;

  logic shift_go;
  logic a_bit, b_bit;
  logic sum_bit, carry_next;
  logic b_fill;

  sadd_seq #(.WIDTH(WIDTH)) seq_i (
    .clk(clk), .rst_n(rst_n), .load(load), .hold(carry_clr),
    .shift_req(shift_en), .shift_go(shift_go), .done(done)
  );

  assign sum_bit    = fa_sum(a_bit, b_bit, carry_out);
  assign carry_next = fa_carry(a_bit, b_bit, carry_out);

  generate
    if (B_RECIRC) begin : g_recirc
      assign b_fill = b_bit;
    end else begin : g_zero_fill
      assign b_fill = 1'b0;
    end
  endgenerate

  sadd_shreg #(.WIDTH(WIDTH)) reg_a_i (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift_go),
    .ser_in(sum_bit), .par_in(op_a), .q(sum_q), .ser_out(a_bit)
  );

  sadd_shreg #(.WIDTH(WIDTH)) reg_b_i (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift_go),
    .ser_in(b_fill), .par_in(op_b), .q(addend_q), .ser_out(b_bit)
  );

  sadd_carry carry_i (
    .clk(clk), .rst_n(rst_n), .clr(load || carry_clr),
    .upd(shift_go), .d(carry_next), .q(carry_out)
  );

  // R8: a clear without load leaves the sum register untouched
  p_clr_no_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_clr && !load) |=> $stable(sum_q) && !carry_out);
  // R2: load clears the carry
  p_load_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !carry_out);
endmodule

// File: tb/serial_adder_tb_top.sv
module serial_adder_tb_top;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int MAX_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic carry_clr = 1'b0, load = 1'b0, shift_en = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [W-1:0] sum_q, addend_q, sum_r, addend_r;
  logic carry_out, done, carry_r, done_r;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_adder #(.WIDTH(W), .B_RECIRC(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .carry_clr(carry_clr), .load(load),
    .op_a(op_a), .op_b(op_b), .shift_en(shift_en),
    .sum_q(sum_q), .addend_q(addend_q), .carry_out(carry_out), .done(done)
  );

  serial_adder #(.WIDTH(W), .B_RECIRC(1'b1)) dut_r (
    .clk(clk), .rst_n(rst_n), .carry_clr(carry_clr), .load(load),
    .op_a(op_a), .op_b(op_b), .shift_en(shift_en),
    .sum_q(sum_r), .addend_q(addend_r), .carry_out(carry_r), .done(done_r)
  );

  function automatic logic [W:0] ref_total(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
    op_a = a; op_b = b; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  // runs W accepted shifts, optionally with random pauses; ends at the negedge after the last edge
  task automatic run_add(input bit gaps, input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    logic [W:0] tot;
    int acc;
    bit en;
    tot = ref_total(a, b);
    acc = 0;
    while (acc < W) begin
      if (done) check(1'b0, "R6 early done", done, 0);
      en = gaps ? ($urandom % 3 != 0) : 1'b1;
      shift_en = en;
      @(negedge clk);
      if (en) acc++;
    end
    shift_en = 1'b0;
    check(done == 1'b1, "R6 done pulse", done, 1);
    check(sum_q == tot[W-1:0], req, sum_q, tot[W-1:0]);
    check(carry_out == tot[W], {req, " carry"}, carry_out, tot[W]);
    check(addend_q == '0, "R9 zero fill", addend_q, 0);
    check(addend_r == b && sum_r == tot[W-1:0], "R9 recirculate", addend_r, b);
    @(negedge clk);
    check(done == 1'b0, "R6 done one cycle", done, 0);
  endtask

  initial begin
    while (cycles < MAX_CYCLES) begin
      @(posedge clk);
      cycles++;
    end
    check(1'b0, "watchdog", cycles, MAX_CYCLES);
    report();
  end

  initial begin
    logic [W-1:0] a, b, s0;
    logic [W:0] lo, hi;
    logic c0;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sum_q == 0 && addend_q == 0 && carry_out == 0 && done == 0, "R1 reset", sum_q, 0);
    rst_n = 1'b1;
    @(negedge clk);
    shift_en = 1'b1;
    repeat (3) @(negedge clk);
    shift_en = 1'b0;
    check(sum_q == 0 && carry_out == 0 && done == 0, "R1 shift ignored before load", sum_q, 0);

    // R2 load
    do_load(8'hA5, 8'h3C);
    check(sum_q == 8'hA5 && addend_q == 8'h3C && carry_out == 0, "R2 load", sum_q, 8'hA5);
    // R4 hold
    repeat (2) @(negedge clk);
    check(sum_q == 8'hA5 && addend_q == 8'h3C, "R4 hold", sum_q, 8'hA5);
    run_add(1'b0, 8'hA5, 8'h3C, "R5 directed");

    // R7 shift after done ignored
    s0 = sum_q; c0 = carry_out;
    shift_en = 1'b1;
    repeat (4) @(negedge clk);
    shift_en = 1'b0;
    check(sum_q == s0 && carry_out == c0 && done == 0, "R7 ignored after done", sum_q, s0);

    // corners: all ones, zero, max carry
    do_load(8'hFF, 8'h01); run_add(1'b0, 8'hFF, 8'h01, "R5 wrap");
    do_load(8'hFF, 8'hFF); run_add(1'b0, 8'hFF, 8'hFF, "R5 max");
    do_load(8'h00, 8'h00); run_add(1'b0, 8'h00, 8'h00, "R5 zero");

    // R3 load with shift and clear in same cycle
    op_a = 8'h12; op_b = 8'h34; load = 1'b1; shift_en = 1'b1; carry_clr = 1'b1;
    @(negedge clk);
    load = 1'b0; shift_en = 1'b0; carry_clr = 1'b0;
    check(sum_q == 8'h12 && addend_q == 8'h34, "R3 load priority", sum_q, 8'h12);
    run_add(1'b0, 8'h12, 8'h34, "R3 count restarted");

    // R8 clear mid-operation: low half adds with carry, high half loses incoming carry
    a = 8'h0F; b = 8'h0F;
    do_load(a, b);
    shift_en = 1'b1;
    repeat (W/2) @(negedge clk);
    shift_en = 1'b1; carry_clr = 1'b1;
    s0 = sum_q;
    @(negedge clk);
    carry_clr = 1'b0; shift_en = 1'b0;
    check(carry_out == 0 && sum_q == s0, "R8 clear holds and zeroes carry", {sum_q, 7'd0, carry_out}, {s0, 8'd0});
    shift_en = 1'b1;
    repeat (W/2) @(negedge clk);
    shift_en = 1'b0;
    lo = {5'd0, a[3:0]} + {5'd0, b[3:0]};
    hi = {5'd0, a[7:4]} + {5'd0, b[7:4]};
    check(done == 1'b1, "R8 count unchanged by clear", done, 1);
    check(sum_q == {hi[3:0], lo[3:0]} && carry_out == hi[4], "R8 split sum", sum_q, {hi[3:0], lo[3:0]});
    @(negedge clk);

    // R10 random operands with random pauses
    for (int i = 0; i < 40; i++) begin
      a = W'($urandom); b = W'($urandom);
      do_load(a, b);
      run_add(1'b1, a, b, "R10 random with gaps");
    end
    report();
  end
endmodule